// File: doc/BRIEF.md
# Byte-Lane Backplane Master Port

This block sits between an internal requester and a shared 16-bit backplane. It accepts one byte or halfword read or write at a time. It drives the backplane address as bits 31 down to 1 only. Address bit 0 and the transfer size are folded into two lane strobes: the upper strobe covers data bits 15:8 and the lower strobe covers bits 7:0.

Once a request is accepted, the block raises the strobe and holds every master-driven signal steady until a peripheral acknowledges. Any number of wait states is allowed. An optional timeout can end a cycle that is never acknowledged. On a read, the selected byte lane is brought down to bits 7:0 of the response.

A separate arbitration node grants the bus through `bus_owner`. Control outputs are enabled only while that grant is held. Write data is enabled only during a write strobe.

Top module: `bytelane_bus_master`

## Requirements
- R1: While the strobe is high, `bus_adr` carries request address bits 31:1 and does not change until the cycle ends.
- R2: `bus_sel` bit 0 qualifies data bits 7:0 and bit 1 qualifies bits 15:8. The encodings are:
  - byte access at an even address gives `2'b01`;
  - byte access at an odd address gives `2'b10`;
  - halfword access gives `2'b11`.
- R3: During a write cycle, `bus_we` is 1 and `bus_dout_oe` is 1. A byte write places the byte on both lanes (`{b,b}`). A halfword write places the 16-bit word unchanged. `bus_dout_oe` is 0 outside write strobes.
- R4: A read response carries:
  - for a halfword read, `bus_din` unchanged;
  - for a byte read, the selected lane in bits 7:0 with bits 15:8 zero.
  A write response carries 0 in `rsp_rdata`.
- R5: The strobe stays high through any number of wait states until `bus_ack` is sampled high. In the next cycle the strobe is low, and `rsp_valid` is high with `rsp_err` = 0 for exactly one cycle.
- R6: A halfword request at an odd address produces, one cycle after acceptance, a one-cycle `rsp_valid` with `rsp_err` = 1. It never raises the strobe.
- R7: `req_ready` is high only while `bus_owner` is high and no strobe is active. `bus_ctl_oe` follows `bus_owner`. A request presented without ownership is ignored: no strobe and no response.
- R8: When `tmo_limit` is nonzero and no acknowledge arrives, the strobe stays high for exactly `tmo_limit` cycles. The cycle then ends with `rsp_valid` and `rsp_err` = 1. A `tmo_limit` of 0 disables the timeout.
- R9: After reset, `bus_stb`, `rsp_valid` and `bus_dout_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Backplane clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_half | input | 1 | 1 = halfword, 0 = byte |
| req_addr | input | AW | Byte address |
| req_wdata | input | 16 | Write data (byte in bits 7:0) |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Misaligned request or timeout |
| rsp_rdata | output | 16 | Steered read data |
| tmo_limit | input | TW | Timeout length in cycles, 0 = off |
| bus_owner | input | 1 | Bus grant from the arbitration node |
| bus_ctl_oe | output | 1 | Output enable for address, lane selects, direction and strobe |
| bus_adr | output | AW-1 | Address bits AW-1:1 |
| bus_sel | output | 2 | Lane strobes |
| bus_we | output | 1 | Write direction |
| bus_stb | output | 1 | Transfer strobe |
| bus_dout | output | 16 | Write data |
| bus_dout_oe | output | 1 | Write data output enable |
| bus_din | input | 16 | Data sensed from the bus |
| bus_ack | input | 1 | Peripheral acknowledge |

## Verification
The bench targets odd byte addresses. A design that decodes the lane select from the wrong address bit would raise the wrong strobe and return the wrong byte from reads. It sends misaligned halfwords, where a faulty design would start a bus cycle instead of answering with an error. It uses acknowledges with zero and with several wait states, and with timeout limits of 1 and 4, where an off-by-one counter would stretch or shorten the strobe. It also presents requests without bus ownership, where a leaky design would drive the backplane or answer.

// File: rtl/bytelane_bus_master.sv
module bytelane_bus_master #(
  parameter int AW = 32,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic          req_half,
  input  logic [AW-1:0] req_addr,
  input  logic [15:0]   req_wdata,
  output logic          rsp_valid,
  output logic          rsp_err,
  output logic [15:0]   rsp_rdata,
  input  logic [TW-1:0] tmo_limit,
  input  logic          bus_owner,
  output logic          bus_ctl_oe,
  output logic [AW-2:0] bus_adr,
  output logic [1:0]    bus_sel,
  output logic          bus_we,
  output logic          bus_stb,
  output logic [15:0]   bus_dout,
  output logic          bus_dout_oe,
  input  logic [15:0]   bus_din,
  input  logic          bus_ack
);
  localparam int LW = 8;

  logic          stb_q, we_q;
  logic [1:0]    sel_q;
  logic [AW-2:0] adr_q;
  logic [15:0]   wd_q, rd_q;
  logic [TW-1:0] cnt_q;
  logic          vld_q, err_q;

  wire accept   = req_valid & req_ready;
  wire misalign = req_half & req_addr[0];
  wire tmo_hit  = (tmo_limit != '0) && (cnt_q == tmo_limit - TW'(1));
  wire [1:0] sel_d = req_half ? 2'b11 : (req_addr[0] ? 2'b10 : 2'b01);
  wire [15:0] wd_d = req_half ? req_wdata : {2{req_wdata[LW-1:0]}};

  logic [15:0] steer;
  always_comb begin
    case (sel_q)
      2'b10:   steer = {{LW{1'b0}}, bus_din[2*LW-1:LW]};
      2'b01:   steer = {{LW{1'b0}}, bus_din[LW-1:0]};
      default: steer = bus_din;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_q <= 1'b0;
      we_q  <= 1'b0;
      sel_q <= 2'b00;
      adr_q <= '0;
      wd_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      vld_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (!stb_q) begin
        if (accept) begin
          if (misalign) begin
            vld_q <= 1'b1;
            err_q <= 1'b1;
            rd_q  <= '0;
          end else begin
            stb_q <= 1'b1;
            we_q  <= req_write;
            sel_q <= sel_d;
            adr_q <= req_addr[AW-1:1];
            wd_q  <= wd_d;
            cnt_q <= '0;
          end
        end
      end else if (bus_ack) begin
        stb_q <= 1'b0;
        vld_q <= 1'b1;
        err_q <= 1'b0;
        rd_q  <= we_q ? 16'h0000 : steer;
      end else if (tmo_hit) begin
        stb_q <= 1'b0;
        vld_q <= 1'b1;
        err_q <= 1'b1;
        rd_q  <= '0;
      end else begin
        cnt_q <= cnt_q + TW'(1);
      end
    end
  end

  assign req_ready   = bus_owner & ~stb_q;
  assign bus_ctl_oe  = bus_owner;
  assign bus_adr     = adr_q;
  assign bus_sel     = stb_q ? sel_q : 2'b00;
  assign bus_we      = stb_q & we_q;
  assign bus_stb     = stb_q;
  assign bus_dout    = wd_q;
  assign bus_dout_oe = bus_owner & stb_q & we_q;
  assign rsp_valid   = vld_q;
  assign rsp_err     = err_q;
  assign rsp_rdata   = rd_q;

  a_r1_adr_stable: assert property (@(posedge clk) disable iff (rst)
    (bus_stb && !bus_ack && !tmo_hit) |=> ($stable(bus_adr) && $stable(bus_sel) && bus_stb));
  a_r2_sel_valid: assert property (@(posedge clk) disable iff (rst)
    bus_stb |-> (bus_sel != 2'b00));
  a_r3_dout_oe: assert property (@(posedge clk) disable iff (rst)
    bus_dout_oe |-> (bus_stb && bus_we && bus_ctl_oe));
  a_r5_drop_after_ack: assert property (@(posedge clk) disable iff (rst)
    (bus_stb && bus_ack) |=> (!bus_stb && rsp_valid && !rsp_err));
  a_r5_hold_no_tmo: assert property (@(posedge clk) disable iff (rst)
    (bus_stb && !bus_ack && tmo_limit == '0) |=> bus_stb);
  a_r6_misalign: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_half && req_addr[0]) |=> (rsp_valid && rsp_err && !bus_stb));
  a_r7_no_owner: assert property (@(posedge clk) disable iff (rst)
    !bus_owner |-> !req_ready);
  a_r5_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
endmodule

// File: tb/bytelane_bus_master_tb_top.sv
module bytelane_bus_master_tb_top;
  logic clk = 0, rst = 1;
  always #10 clk = ~clk;

  logic req_valid = 0, req_write = 0, req_half = 0;
  logic [31:0] req_addr = 0;
  logic [15:0] req_wdata = 0, bus_din = 0;
  logic [15:0] tmo_limit = 0;
  logic bus_owner = 1, bus_ack = 0;
  logic req_ready, rsp_valid, rsp_err, bus_ctl_oe, bus_we, bus_stb, bus_dout_oe;
  logic [15:0] rsp_rdata, bus_dout;
  logic [30:0] bus_adr;
  logic [1:0] bus_sel;

  int checks = 0, failures = 0;

  bytelane_bus_master dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_half(req_half), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .tmo_limit(tmo_limit), .bus_owner(bus_owner),
    .bus_ctl_oe(bus_ctl_oe), .bus_adr(bus_adr), .bus_sel(bus_sel),
    .bus_we(bus_we), .bus_stb(bus_stb), .bus_dout(bus_dout),
    .bus_dout_oe(bus_dout_oe), .bus_din(bus_din), .bus_ack(bus_ack)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_sel(logic half, logic a0);
    return half ? 2'b11 : (a0 ? 2'b10 : 2'b01);
  endfunction
  function automatic logic [15:0] exp_dout(logic half, logic [15:0] d);
    return half ? d : {d[7:0], d[7:0]};
  endfunction
  function automatic logic [15:0] exp_rd(logic half, logic a0, logic [15:0] d);
    if (half) return d;
    return a0 ? {8'h00, d[15:8]} : {8'h00, d[7:0]};
  endfunction

  task automatic access(logic wr, logic half, logic [31:0] a, logic [15:0] wd,
                        int waits, logic [15:0] din);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_half = half; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    if (half && a[0]) begin
      chk("R6 err rsp_valid", rsp_valid, 1);
      chk("R6 err rsp_err", rsp_err, 1);
      chk("R6 no strobe", bus_stb, 0);
      @(negedge clk);
      chk("R6 no later strobe", bus_stb, 0);
      return;
    end
    chk("R5 strobe up", bus_stb, 1);
    chk("R1 address", bus_adr, a[31:1]);
    chk("R2 lane select", bus_sel, exp_sel(half, a[0]));
    chk("R3 direction", bus_we, wr);
    chk("R3 dout_oe", bus_dout_oe, wr);
    if (wr) chk("R3 write data", bus_dout, exp_dout(half, wd));
    for (int i = 0; i < waits; i++) begin
      @(negedge clk);
      chk("R5 strobe held", bus_stb, 1);
      chk("R1 address held", bus_adr, a[31:1]);
      chk("R5 no early rsp", rsp_valid, 0);
    end
    bus_ack = 1; bus_din = din;
    @(negedge clk);
    bus_ack = 0; bus_din = 16'hxxxx;
    chk("R5 strobe dropped", bus_stb, 0);
    chk("R5 rsp_valid", rsp_valid, 1);
    chk("R5 rsp_err", rsp_err, 0);
    chk("R3 dout_oe off", bus_dout_oe, 0);
    chk("R4 read data", rsp_rdata, wr ? 16'h0000 : exp_rd(half, a[0], din));
    @(negedge clk);
    chk("R5 one-cycle rsp", rsp_valid, 0);
  endtask

  task automatic timeout_case(int lim);
    tmo_limit = 16'(lim);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_half = 0; req_addr = 32'h100; 
    @(negedge clk);
    req_valid = 0;
    chk("R8 strobe up", bus_stb, 1);
    for (int i = 1; i < lim; i++) begin
      @(negedge clk);
      chk("R8 strobe held", bus_stb, 1);
    end
    @(negedge clk);
    chk("R8 strobe ended", bus_stb, 0);
    chk("R8 rsp_valid", rsp_valid, 1);
    chk("R8 rsp_err", rsp_err, 1);
    tmo_limit = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    chk("R9 stb reset", bus_stb, 0);
    chk("R9 rsp reset", rsp_valid, 0);
    chk("R9 dout_oe reset", bus_dout_oe, 0);
    rst = 0;
    @(negedge clk);
    chk("R7 ready when owner", req_ready, 1);

    access(1, 0, 32'h0000_1001, 16'h00a5, 0, 0);
    access(1, 0, 32'h0000_1000, 16'h003c, 2, 0);
    access(1, 1, 32'h8000_0002, 16'hbeef, 1, 0);
    access(0, 0, 32'h0000_2003, 0, 3, 16'h12ab);
    access(0, 0, 32'h0000_2002, 0, 0, 16'h12ab);
    access(0, 1, 32'hfffffffe, 0, 5, 16'hc0de);
    access(0, 1, 32'h0000_0005, 0, 0, 16'h0);
    access(1, 1, 32'h0000_0007, 16'h1234, 0, 0);

    bus_owner = 0;
    @(negedge clk);
    chk("R7 ctl_oe off", bus_ctl_oe, 0);
    chk("R7 not ready", req_ready, 0);
    req_valid = 1; req_addr = 32'h40; req_half = 0; req_write = 1;
    repeat (3) begin
      @(negedge clk);
      chk("R7 ignored no strobe", bus_stb, 0);
      chk("R7 ignored no rsp", rsp_valid, 0);
    end
    req_valid = 0;
    bus_owner = 1;
    @(negedge clk);
    chk("R7 ctl_oe on", bus_ctl_oe, 1);

    timeout_case(1);
    timeout_case(4);
    access(0, 0, 32'h0000_0011, 0, 6, 16'h7e81);

    for (int n = 0; n < 200; n++) begin
      logic wr, hf;
      logic [31:0] a;
      logic [15:0] wd, dn;
      int w;
      wr = 1'($urandom);
      hf = 1'($urandom);
      a  = $urandom;
      wd = 16'($urandom);
      dn = 16'($urandom);
      w  = int'($urandom % 6);
      access(wr, hf, a, wd, w, dn);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule